// File: doc/BRIEF.md
# Bus Cycle Strobe Sequencer

This block produces the control strobes for one read or one write transfer on a 16-bit parallel peripheral bus with a latched address. It assumes the address, and for a write the data, are already held in registers elsewhere. A single-cycle start request with a read/write select launches a transfer. The block then steps through a fixed, ordered list of strobe states and returns to idle with a one-cycle completion pulse.

Every transfer opens with one high pulse on the address-latch strobe. A read then enables the bus transceiver, lowers the read strobe and opens the capture latch. It closes these in reverse order. A write raises the direction line, holds the write strobe low for a long programmable time (about 1 ms, given in clock cycles), releases it, and then drops the direction line. Every step other than the write-strobe-low step lasts a programmable setup interval, which keeps bus setup and hold margins.

Top module: `bus_cycle_seq`

## Requirements
- R1: Out of reset and whenever idle, the strobes sit at: ale_o=0, rd_n_o=1, wr_n_o=1, dir_o=0, xcvr_en_n_o=1, cap_n_o=1, busy_o=0, done_o=0.
- R2: A start_i seen high while idle makes busy_o and ale_o go high from the next clock. ale_o stays high for SETUP_CYC cycles, then low for SETUP_CYC cycles with every other strobe still at its idle level. ale_o pulses exactly once per transfer.
- R3: A read (write_i=0 at start) then lowers xcvr_en_n_o, then rd_n_o, then cap_n_o. Each change adds to the previous one and holds for SETUP_CYC cycles.
- R4: A read closes in the order cap_n_o high, then rd_n_o high, then xcvr_en_n_o high. Each of the first two states lasts SETUP_CYC cycles, and the last change coincides with the return to idle.
- R5: A write (write_i=1 at start) raises dir_o for SETUP_CYC cycles, then holds wr_n_o low with dir_o high for exactly WR_LOW_CYC cycles, then keeps dir_o high with wr_n_o high for SETUP_CYC cycles, then lowers dir_o on the return to idle.
- R6: rd_n_o and wr_n_o are never low together. rd_n_o low implies xcvr_en_n_o low, cap_n_o low implies rd_n_o low, and wr_n_o low implies dir_o high.
- R7: start_i and write_i are ignored while busy_o is high. A start pulse during a transfer neither changes its sequence nor queues another transfer.
- R8: done_o is high for exactly one cycle, in the first idle cycle after a transfer, and busy_o is low in that cycle. busy_o is high for the whole transfer: 7*SETUP_CYC cycles for a read, 4*SETUP_CYC+WR_LOW_CYC for a write.
- R9: start_i held high continuously gives back-to-back transfers separated by exactly one idle cycle (the done cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a transfer (sampled only when idle) |
| write_i | input | 1 | 1 = write transfer, 0 = read transfer (sampled with start_i) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ale_o | output | 1 | Address latch strobe, active high |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| dir_o | output | 1 | Data direction, 1 = toward the bus |
| xcvr_en_n_o | output | 1 | Transceiver enable, active low |
| cap_n_o | output | 1 | Read-data capture latch enable, active low |

## Verification
The properties assume that SETUP_CYC and WR_LOW_CYC are at least one. They also assume that start_i and write_i are synchronous to clk_i; no other condition is placed on them, so the nesting and exclusivity properties must hold for any request pattern. The stimulus changes inputs only at falling edges. It sends start pulses in the middle of transfers, including pulses with the opposite direction select, and holds start_i high across consecutive transfers. It uses small parameter values, so the long write-strobe window is covered in full.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ALE_HI,
        ST_ALE_LO,
        ST_R_XEN,
        ST_R_RD,
        ST_R_CAP,
        ST_R_CAPREL,
        ST_R_RDREL,
        ST_W_DIR,
        ST_W_STROBE,
        ST_W_HOLD
    } seq_state_e;

    typedef struct packed {
        logic ale;
        logic rd_n;
        logic wr_n;
        logic dir;
        logic xen_n;
        logic cap_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = 6'b011011;

    typedef struct packed {
        seq_state_e state;
        logic       is_wr;
        logic       busy;
        logic       done;
        strobe_t    strb;
    } seq_regs_t;

    // Bus levels driven in each sequencer state.
    function automatic strobe_t strobe_of(seq_state_e s);
        strobe_t v;
        v = STROBE_IDLE;
        case (s)
            ST_ALE_HI:   v.ale = 1'b1;
            ST_R_XEN:    v.xen_n = 1'b0;
            ST_R_RD:     begin v.xen_n = 1'b0; v.rd_n = 1'b0; end
            ST_R_CAP:    begin v.xen_n = 1'b0; v.rd_n = 1'b0; v.cap_n = 1'b0; end
            ST_R_CAPREL: begin v.xen_n = 1'b0; v.rd_n = 1'b0; end
            ST_R_RDREL:  v.xen_n = 1'b0;
            ST_W_DIR:    v.dir = 1'b1;
            ST_W_STROBE: begin v.dir = 1'b1; v.wr_n = 1'b0; end
            ST_W_HOLD:   v.dir = 1'b1;
            default:     v = STROBE_IDLE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bcs_step_timer.sv
module bcs_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Loading N gives exactly N cycles before expiry is seen.
    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/bcs_step_order.sv
module bcs_step_order
    import bcs_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       is_wr_i,
    output seq_state_e succ_o,
    output logic       long_step_o
);
    always_comb begin
        succ_o = ST_IDLE;
        case (state_i)
            ST_ALE_HI:   succ_o = ST_ALE_LO;
            ST_ALE_LO:   succ_o = is_wr_i ? ST_W_DIR : ST_R_XEN;
            ST_R_XEN:    succ_o = ST_R_RD;
            ST_R_RD:     succ_o = ST_R_CAP;
            ST_R_CAP:    succ_o = ST_R_CAPREL;
            ST_R_CAPREL: succ_o = ST_R_RDREL;
            ST_R_RDREL:  succ_o = ST_IDLE;
            ST_W_DIR:    succ_o = ST_W_STROBE;
            ST_W_STROBE: succ_o = ST_W_HOLD;
            ST_W_HOLD:   succ_o = ST_IDLE;
            default:     succ_o = ST_IDLE;
        endcase
    end

    // The write-strobe step uses the long interval.
    assign long_step_o = (succ_o == ST_W_STROBE);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int SETUP_CYC  = 4,
    parameter int WR_LOW_CYC = 250000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic write_i,
    output logic busy_o,
    output logic done_o,
    output logic ale_o,
    output logic rd_n_o,
    output logic wr_n_o,
    output logic dir_o,
    output logic xcvr_en_n_o,
    output logic cap_n_o
);
    localparam int MAX_CYC = (WR_LOW_CYC > SETUP_CYC) ? WR_LOW_CYC : SETUP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_V = CNT_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] WRLOW_V = CNT_W'(WR_LOW_CYC);

    seq_regs_t        r_d, r_q;
    seq_state_e       succ;
    logic             long_step;
    logic             expire;
    logic             load;
    logic [CNT_W-1:0] load_val;

    bcs_step_order u_order (
        .state_i     (r_q.state),
        .is_wr_i     (r_q.is_wr),
        .succ_o      (succ),
        .long_step_o (long_step)
    );

    bcs_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_val_i (load_val),
        .expire_o   (expire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;
        load_val = SETUP_V;
        if (r_q.state == ST_IDLE) begin
            if (start_i) begin
                r_d.state = ST_ALE_HI;
                r_d.is_wr = write_i;
                load      = 1'b1;
            end
        end else if (expire) begin
            r_d.state = succ;
            if (succ == ST_IDLE) begin
                r_d.done = 1'b1;
            end else begin
                load     = 1'b1;
                load_val = long_step ? WRLOW_V : SETUP_V;
            end
        end
        r_d.busy = (r_d.state != ST_IDLE);
        r_d.strb = strobe_of(r_d.state);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_IDLE;
            r_q.is_wr <= 1'b0;
            r_q.busy  <= 1'b0;
            r_q.done  <= 1'b0;
            r_q.strb  <= STROBE_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = r_q.busy;
    assign done_o      = r_q.done;
    assign ale_o       = r_q.strb.ale;
    assign rd_n_o      = r_q.strb.rd_n;
    assign wr_n_o      = r_q.strb.wr_n;
    assign dir_o       = r_q.strb.dir;
    assign xcvr_en_n_o = r_q.strb.xen_n;
    assign cap_n_o     = r_q.strb.cap_n;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int SETUP_CYC  = 4,
    parameter int WR_LOW_CYC = 250000
) (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic ale_o,
    input logic rd_n_o,
    input logic wr_n_o,
    input logic dir_o,
    input logic xcvr_en_n_o,
    input logic cap_n_o
);
    int wr_low_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      wr_low_cnt <= 0;
        else if (!wr_n_o) wr_low_cnt <= wr_low_cnt + 1;
        else              wr_low_cnt <= 0;
    end

    a_r1_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!ale_o && rd_n_o && wr_n_o && !dir_o && xcvr_en_n_o && cap_n_o));

    a_r2_start_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && ale_o));

    a_r3_rd_needs_xcvr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_n_o |-> !xcvr_en_n_o);

    a_r3_cap_needs_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_n_o |-> !rd_n_o);

    a_r5_wr_needs_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_n_o |-> dir_o);

    a_r5_wr_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_n_o) |-> (wr_low_cnt == WR_LOW_CYC));

    a_r6_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!rd_n_o && !wr_n_o));

    a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r8_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
endmodule

bind bus_cycle_seq bcs_checker #(
    .SETUP_CYC  (SETUP_CYC),
    .WR_LOW_CYC (WR_LOW_CYC)
) u_bcs_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ale_o       (ale_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o),
    .dir_o       (dir_o),
    .xcvr_en_n_o (xcvr_en_n_o),
    .cap_n_o     (cap_n_o)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
    localparam int S = 3;
    localparam int W = 40;
    // vector order {ale, rd_n, wr_n, dir, xen_n, cap_n}
    localparam logic [5:0] V_IDLE   = 6'b011011;
    localparam logic [5:0] V_ALEHI  = 6'b111011;
    localparam logic [5:0] V_XEN    = 6'b011001;
    localparam logic [5:0] V_RD     = 6'b001001;
    localparam logic [5:0] V_CAP    = 6'b001000;
    localparam logic [5:0] V_DIR    = 6'b011111;
    localparam logic [5:0] V_WRLOW  = 6'b010111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic write = 1'b0;
    logic busy, done, ale, rd_n, wr_n, dir, xen_n, cap_n;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [5:0] q_vec[$];
    int         q_len[$];
    string      q_tag[$];

    logic [5:0] cur_vec;
    int         run_len = 0;
    logic       prev_done = 1'b0;

    always #2 clk = ~clk;

    bus_cycle_seq #(.SETUP_CYC(S), .WR_LOW_CYC(W)) u_bus_cycle_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(write),
        .busy_o(busy), .done_o(done), .ale_o(ale), .rd_n_o(rd_n),
        .wr_n_o(wr_n), .dir_o(dir), .xcvr_en_n_o(xen_n), .cap_n_o(cap_n)
    );

    function automatic logic [5:0] vec_now();
        return {ale, rd_n, wr_n, dir, xen_n, cap_n};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [5:0] v, input int n, input string tag);
        q_vec.push_back(v);
        q_len.push_back(n);
        q_tag.push_back(tag);
    endtask

    task automatic close_run();
        if (q_vec.size() == 0) begin
            check(1'b0, "R7 unexpected strobe run", int'(cur_vec), 0);
        end else begin
            logic [5:0] ev;
            int         el;
            string      et;
            ev = q_vec.pop_front();
            el = q_len.pop_front();
            et = q_tag.pop_front();
            check(cur_vec == ev, {et, " strobe levels"}, int'(cur_vec), int'(ev));
            check(run_len == el, {et, " step length"}, run_len, el);
        end
    endtask

    // Monitor: split the busy window into runs of constant strobe levels.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [5:0] v;
            v = vec_now();
            if (!rd_n && !wr_n) check(1'b0, "R6 both strobes low", int'(v), 0);
            if (busy) begin
                if (run_len > 0 && v == cur_vec) begin
                    run_len++;
                end else begin
                    if (run_len > 0) close_run();
                    cur_vec = v;
                    run_len = 1;
                end
            end else if (run_len > 0) begin
                close_run();
                run_len = 0;
            end
            if (done) begin
                check(!busy && v == V_IDLE, "R8 done in idle cycle", int'({busy, v}), int'(V_IDLE));
                check(!prev_done, "R8 done single cycle", 1, 0);
            end
            prev_done = done;
        end
    end

    task automatic expect_read();
        push(V_ALEHI, S, "R2");
        push(V_IDLE,  S, "R2");
        push(V_XEN,   S, "R3");
        push(V_RD,    S, "R3");
        push(V_CAP,   S, "R3");
        push(V_RD,    S, "R4");
        push(V_XEN,   S, "R4");
    endtask

    task automatic expect_write();
        push(V_ALEHI, S, "R2");
        push(V_IDLE,  S, "R2");
        push(V_DIR,   S, "R5");
        push(V_WRLOW, W, "R5");
        push(V_DIR,   S, "R5");
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // One transfer; poke > 0 sends an extra start with the opposite select.
    task automatic transfer(input bit wr, input int poke);
        int blen;
        if (wr) expect_write(); else expect_read();
        @(negedge clk);
        start = 1'b1;
        write = wr;
        @(negedge clk);
        start = 1'b0;
        blen = 0;
        while (busy) begin
            blen++;
            if (blen == poke) begin
                start = 1'b1;
                write = !wr;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(blen == (wr ? 4 * S + W : 7 * S), "R8 busy length", blen, wr ? 4 * S + W : 7 * S);
        check(done == 1'b1, "R8 done at busy fall", int'(done), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!busy, "R7 no queued transfer", int'(busy), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(vec_now() == V_IDLE && !busy && !done, "R1 reset levels",
              int'({busy, done, vec_now()}), int'(V_IDLE));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(vec_now() == V_IDLE && !busy, "R1 idle after release", int'(vec_now()), int'(V_IDLE));

        transfer(1'b0, 0);
        transfer(1'b1, 0);
        transfer(1'b0, 5);
        transfer(1'b1, 20);
        transfer(1'b1, 1);

        // R9: start held high gives back-to-back transfers
        expect_read();
        expect_write();
        @(negedge clk);
        start = 1'b1;
        write = 1'b0;
        @(negedge clk);
        wait_done();
        write = 1'b1;
        check(!busy, "R9 one idle cycle between", int'(busy), 0);
        @(negedge clk);
        check(busy && ale, "R9 next transfer starts", int'({busy, ale}), 3);
        wait_done();
        start = 1'b0;
        @(negedge clk);
        check(!busy, "R9 stops when released", int'(busy), 0);
        repeat (3) @(negedge clk);

        check(q_vec.size() == 0, "R7 all expected runs seen", q_vec.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule